// File: doc/BRIEF.md
# Output Neuron Class Labeler

After an unsupervised training run, each output neuron of a spiking network has to be given a class, or be left out of classification. This block watches a labeling pass: every output spike arrives as an event that carries the neuron's index and the class tag of the sample on show. For each neuron the block keeps a saturating spike count and the class tags of its ten most recent spikes.

When the finalise command arrives, the block walks over the neurons one per cycle. It tallies the classes in each neuron's history. A neuron gets a label only when it has fired at least ten times and a single class holds six or more of its last ten tags. Otherwise the neuron is disabled. A one-cycle done pulse marks the end of the pass. The outcome can then be read through an index-addressed port until the next pass or clear.

Top module: `neuron_class_labeler`

## Requirements
- R1: After reset, done_o is low and every neuron index reads back with enable 0 and label 0.
- R2: Each accepted event increments the addressed neuron's spike count. The count saturates instead of wrapping. The event's class tag is stored in that neuron's 10-deep history, and the oldest tag is overwritten once the history is full.
- R3: A neuron with fewer than 10 accepted events reads disabled after a pass, whatever its tags.
- R4: A neuron with at least 10 accepted events, where one class value holds 6 or more of its last 10 tags, reads enabled after a pass. Its 4-bit label equals that class value.
- R5: A neuron where no class reaches 6 of its last 10 tags reads disabled after a pass. A disabled neuron always reads label 0.
- R6: Only the last 10 tags of a neuron vote. Older tags have no influence on the label.
- R7: A finalise sampled at clock edge E0 while idle produces exactly one done cycle, which begins at edge E0+100 (one neuron per cycle).
- R8: Events and finalise requests that arrive while a pass is running are ignored.
- R9: Events whose neuron index is 100 or more are ignored.
- R10: A clear zeroes all counts and results, and abandons a running pass without a done pulse.
- R11: Results hold until the next pass or clear. A read index of 100 or more returns enable 0 and label 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counts, histories and results |
| ev_valid_i | input | 1 | Spike event strobe |
| ev_neuron_i | input | 7 | Index of the neuron that spiked |
| ev_class_i | input | 4 | Class tag of the sample being shown |
| finalise_i | input | 1 | Start a labeling pass over all neurons |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| rd_neuron_i | input | 7 | Neuron index for result read |
| rd_enable_o | output | 1 | Enable bit of the addressed neuron |
| rd_label_o | output | 4 | Label of the addressed neuron |

## Verification
The bench sweeps all hundred neurons with spike totals from 5 to 24 and four tag mixes:
- a single class,
- a 5/5 split,
- a 6/4 split that sits exactly on the threshold,
- a 5/4/1 spread.

Each mix is checked against a model of the last ten tags. A design that compared with greater-than would drop the 6/4 neurons, and one that counted all spikes rather than the last ten would mislabel neurons whose history was later overwritten. Three hundred extra spikes into one neuron catch a wrapping counter, which would see too few spikes and disable it. Injecting spikes and a second finalise mid-pass, then clearing mid-pass, exposes a design that accepts work while busy or still raises done after an abort.

// File: rtl/nlab_pkg.sv
`timescale 1ns/1ps
package nlab_pkg;
    typedef enum logic [0:0] {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;
endpackage

// File: rtl/nlab_history.sv
`timescale 1ns/1ps
// Per-neuron spike counters, ring write pointers and class tag storage.
module nlab_history #(
    parameter int N       = 100,
    parameter int HIST    = 10,
    parameter int TAG_W   = 4,
    parameter int CNT_MAX = 10,
    parameter int IDX_W   = 7,
    parameter int CNT_W   = 4,
    parameter int PTR_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    wr_en_i,
    input  logic [IDX_W-1:0]        wr_idx_i,
    input  logic [TAG_W-1:0]        wr_tag_i,
    input  logic [IDX_W-1:0]        rd_idx_i,
    output logic [HIST*TAG_W-1:0]   rd_tags_o,
    output logic [CNT_W-1:0]        rd_cnt_o
);
    typedef struct packed {
        logic [N-1:0][CNT_W-1:0] cnt;
        logic [N-1:0][PTR_W-1:0] ptr;
    } hist_state_t;

    hist_state_t st_d, st_q;
    logic        wr_ok;
    logic [TAG_W-1:0] tag_mem [N][HIST];

    assign wr_ok = wr_en_i && !clr_i && (32'(wr_idx_i) < N);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (wr_ok) begin
            if (32'(st_q.cnt[wr_idx_i]) != CNT_MAX)
                st_d.cnt[wr_idx_i] = st_q.cnt[wr_idx_i] + 1'b1;
            if (32'(st_q.ptr[wr_idx_i]) == HIST - 1)
                st_d.ptr[wr_idx_i] = '0;
            else
                st_d.ptr[wr_idx_i] = st_q.ptr[wr_idx_i] + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Tag storage needs no reset: entries beyond the fill level are masked.
    always_ff @(posedge clk) begin
        if (wr_ok) tag_mem[wr_idx_i][st_q.ptr[wr_idx_i]] <= wr_tag_i;
    end

    assign rd_cnt_o = st_q.cnt[rd_idx_i];

    for (genvar i = 0; i < HIST; i++) begin : g_rd
        assign rd_tags_o[i*TAG_W +: TAG_W] = tag_mem[rd_idx_i][i];
    end
endmodule

// File: rtl/nlab_vote.sv
`timescale 1ns/1ps
// Majority vote over one neuron's stored tags.
module nlab_vote #(
    parameter int HIST       = 10,
    parameter int TAG_W      = 4,
    parameter int VOTE_MIN   = 6,
    parameter int MIN_SPIKES = 10,
    parameter int CNT_W      = 4
) (
    input  logic [HIST*TAG_W-1:0] tags_i,
    input  logic [CNT_W-1:0]      cnt_i,
    output logic                  enable_o,
    output logic [TAG_W-1:0]      label_o
);
    localparam int NUM_CLASS = 1 << TAG_W;
    localparam int TALLY_W   = $clog2(HIST + 1);

    logic [HIST-1:0]    live;
    logic [TALLY_W-1:0] tally [NUM_CLASS];
    logic               found;
    logic [TAG_W-1:0]   winner;

    // Slot i holds a real tag once at least i+1 events were written.
    for (genvar i = 0; i < HIST; i++) begin : g_live
        assign live[i] = 32'(cnt_i) > i;
    end

    always_comb begin
        for (int c = 0; c < NUM_CLASS; c++) begin
            tally[c] = '0;
            for (int i = 0; i < HIST; i++) begin
                if (live[i] && tags_i[i*TAG_W +: TAG_W] == TAG_W'(c))
                    tally[c] = tally[c] + 1'b1;
            end
        end
    end

    always_comb begin
        found  = 1'b0;
        winner = '0;
        for (int c = 0; c < NUM_CLASS; c++) begin
            if (!found && 32'(tally[c]) >= VOTE_MIN) begin
                found  = 1'b1;
                winner = TAG_W'(c);
            end
        end
    end

    assign enable_o = found && (32'(cnt_i) >= MIN_SPIKES);
    assign label_o  = enable_o ? winner : '0;
endmodule

// File: rtl/nlab_scan.sv
`timescale 1ns/1ps
// Walks the neurons one per cycle and latches each vote result.
module nlab_scan
    import nlab_pkg::*;
#(
    parameter int N     = 100,
    parameter int IDX_W = 7,
    parameter int TAG_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr_i,
    input  logic                      start_i,
    input  logic                      vote_en_i,
    input  logic [TAG_W-1:0]          vote_label_i,
    output logic [IDX_W-1:0]          scan_idx_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [N-1:0]              res_en_o,
    output logic [N-1:0][TAG_W-1:0]   res_label_o
);
    typedef struct packed {
        scan_state_e              st;
        logic [IDX_W-1:0]         idx;
        logic                     done;
        logic [N-1:0]             en;
        logic [N-1:0][TAG_W-1:0]  lab;
    } scan_t;

    scan_t sc_d, sc_q;

    always_comb begin
        sc_d      = sc_q;
        sc_d.done = 1'b0;
        if (clr_i) begin
            sc_d = '0;
        end else begin
            unique case (sc_q.st)
                SCAN_IDLE: begin
                    if (start_i) begin
                        sc_d.st  = SCAN_RUN;
                        sc_d.idx = '0;
                    end
                end
                SCAN_RUN: begin
                    sc_d.en[sc_q.idx]  = vote_en_i;
                    sc_d.lab[sc_q.idx] = vote_label_i;
                    if (32'(sc_q.idx) == N - 1) begin
                        sc_d.st   = SCAN_IDLE;
                        sc_d.done = 1'b1;
                    end else begin
                        sc_d.idx = sc_q.idx + 1'b1;
                    end
                end
                default: sc_d.st = SCAN_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign scan_idx_o  = sc_q.idx;
    assign busy_o      = sc_q.st == SCAN_RUN;
    assign done_o      = sc_q.done;
    assign res_en_o    = sc_q.en;
    assign res_label_o = sc_q.lab;
endmodule

// File: rtl/neuron_class_labeler.sv
`timescale 1ns/1ps
module neuron_class_labeler #(
    parameter int NUM_NEURONS = 100,
    parameter int HIST_LEN    = 10,
    parameter int MIN_SPIKES  = 10,
    parameter int VOTE_MIN    = 6,
    parameter int TAG_W       = 4,
    localparam int IDX_W      = $clog2(NUM_NEURONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              ev_valid_i,
    input  logic [IDX_W-1:0]  ev_neuron_i,
    input  logic [TAG_W-1:0]  ev_class_i,
    input  logic              finalise_i,
    output logic              done_o,
    input  logic [IDX_W-1:0]  rd_neuron_i,
    output logic              rd_enable_o,
    output logic [TAG_W-1:0]  rd_label_o
);
    localparam int CNT_MAX = (MIN_SPIKES > HIST_LEN) ? MIN_SPIKES : HIST_LEN;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int PTR_W   = $clog2(HIST_LEN);

    logic [HIST_LEN*TAG_W-1:0]          cur_tags;
    logic [CNT_W-1:0]                   cur_cnt;
    logic [IDX_W-1:0]                   scan_idx;
    logic                               scan_busy;
    logic                               vote_en;
    logic [TAG_W-1:0]                   vote_label;
    logic [NUM_NEURONS-1:0]             res_en;
    logic [NUM_NEURONS-1:0][TAG_W-1:0]  res_label;
    logic                               rd_in_range;

    nlab_history #(
        .N(NUM_NEURONS), .HIST(HIST_LEN), .TAG_W(TAG_W), .CNT_MAX(CNT_MAX),
        .IDX_W(IDX_W), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) hist_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .wr_en_i(ev_valid_i && !scan_busy),
        .wr_idx_i(ev_neuron_i), .wr_tag_i(ev_class_i),
        .rd_idx_i(scan_idx), .rd_tags_o(cur_tags), .rd_cnt_o(cur_cnt)
    );

    nlab_vote #(
        .HIST(HIST_LEN), .TAG_W(TAG_W), .VOTE_MIN(VOTE_MIN),
        .MIN_SPIKES(MIN_SPIKES), .CNT_W(CNT_W)
    ) vote_i (
        .tags_i(cur_tags), .cnt_i(cur_cnt),
        .enable_o(vote_en), .label_o(vote_label)
    );

    nlab_scan #(
        .N(NUM_NEURONS), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) scan_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(finalise_i),
        .vote_en_i(vote_en), .vote_label_i(vote_label),
        .scan_idx_o(scan_idx), .busy_o(scan_busy), .done_o(done_o),
        .res_en_o(res_en), .res_label_o(res_label)
    );

    assign rd_in_range = 32'(rd_neuron_i) < NUM_NEURONS;
    assign rd_enable_o = rd_in_range ? res_en[rd_neuron_i] : 1'b0;
    assign rd_label_o  = rd_in_range ? res_label[rd_neuron_i] : '0;
endmodule

// File: rtl/nlab_checker.sv
`timescale 1ns/1ps
module nlab_checker #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_i,
    input logic             finalise_i,
    input logic             busy,
    input logic             done_o,
    input logic             rd_enable_o,
    input logic [TAG_W-1:0] rd_label_o
);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r7_done_after_scan: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));

    a_r7_start_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (finalise_i && !busy && !clr_i) |=> busy);

    a_r8_scan_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clr_i) |=> (busy || done_o));

    a_r10_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!busy && !done_o));

    a_r5_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_enable_o |-> (rd_label_o == '0));
endmodule

bind neuron_class_labeler nlab_checker #(.TAG_W(TAG_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .finalise_i(finalise_i),
    .busy(scan_busy), .done_o(done_o),
    .rd_enable_o(rd_enable_o), .rd_label_o(rd_label_o)
);

// File: tb/neuron_class_labeler_tb_top.sv
`timescale 1ns/1ps
module neuron_class_labeler_tb_top;
    localparam int NN = 100;
    localparam int HL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_i = 1'b0;
    logic       ev_valid_i = 1'b0;
    logic [6:0] ev_neuron_i = '0;
    logic [3:0] ev_class_i = '0;
    logic       finalise_i = 1'b0;
    logic       done_o;
    logic [6:0] rd_neuron_i = '0;
    logic       rd_enable_o;
    logic [3:0] rd_label_o;

    int checks = 0;
    int errors = 0;

    int m_cnt  [NN];
    int m_hist [NN][HL];
    int m_ptr  [NN];

    always #10 clk = ~clk;

    neuron_class_labeler dut_i (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .ev_valid_i(ev_valid_i), .ev_neuron_i(ev_neuron_i), .ev_class_i(ev_class_i),
        .finalise_i(finalise_i), .done_o(done_o),
        .rd_neuron_i(rd_neuron_i), .rd_enable_o(rd_enable_o), .rd_label_o(rd_label_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int spikes_of(int n);
        return 5 + (n * 7) % 20;
    endfunction

    function automatic int tag_of(int n, int j);
        int a = n % 16;
        int b = (n + 5) % 16;
        int c = (n + 9) % 16;
        case (n % 4)
            0: return a;
            1: return (j % 2 != 0) ? a : b;
            2: return (j % 5 < 3) ? a : b;
            default: return (j % 10 < 5) ? a : ((j % 10 < 9) ? b : c);
        endcase
    endfunction

    task automatic model_clear();
        for (int n = 0; n < NN; n++) begin
            m_cnt[n] = 0;
            m_ptr[n] = 0;
            for (int i = 0; i < HL; i++) m_hist[n][i] = 0;
        end
    endtask

    // Drive one event at a negedge; the model is updated only for in-range neurons.
    task automatic send_ev(input int n, input int c);
        ev_valid_i  = 1'b1;
        ev_neuron_i = 7'(n);
        ev_class_i  = 4'(c);
        @(negedge clk);
        ev_valid_i  = 1'b0;
        if (n < NN) begin
            m_hist[n][m_ptr[n]] = c;
            m_ptr[n] = (m_ptr[n] + 1) % HL;
            m_cnt[n]++;
        end
    endtask

    function automatic void expect_of(input int n, output bit en, output int lab);
        int fill = (m_cnt[n] < HL) ? m_cnt[n] : HL;
        en  = 1'b0;
        lab = 0;
        for (int c = 0; c < 16; c++) begin
            int t = 0;
            for (int i = 0; i < fill; i++) if (m_hist[n][i] == c) t++;
            if (t >= 6 && m_cnt[n] >= 10 && !en) begin
                en  = 1'b1;
                lab = c;
            end
        end
    endfunction

    task automatic check_all(input string req);
        for (int n = 0; n < NN; n++) begin
            bit en;
            int lab;
            expect_of(n, en, lab);
            rd_neuron_i = 7'(n);
            #1;
            check(rd_enable_o == en && int'(rd_label_o) == lab, req,
                  {rd_enable_o, rd_label_o}, {en, 4'(lab)});
        end
    endtask

    // Launch a pass and verify the single done cycle; optional mid-pass stimulus.
    task automatic run_final(input bit inject, input string req);
        int seen = 0;
        int at = -1;
        finalise_i = 1'b1;
        @(negedge clk);
        finalise_i = 1'b0;
        for (int k = 1; k <= NN + 5; k++) begin
            if (done_o) begin
                seen++;
                at = k;
            end
            if (inject) begin
                ev_valid_i  = (k >= 2 && k < 12);
                ev_neuron_i = 7'd1;
                ev_class_i  = 4'd3;
                finalise_i  = (k == 50);
            end
            @(negedge clk);
        end
        ev_valid_i = 1'b0;
        finalise_i = 1'b0;
        check(seen == 1, req, seen, 1);
        check(at == NN + 1, req, at, NN + 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check_all("R1");

        // R2 R3 R4 R5 R9: interleaved sweep with out-of-range events mixed in
        for (int j = 0; j < 25; j++) begin
            for (int n = 0; n < NN; n++)
                if (j < spikes_of(n)) send_ev(n, tag_of(n, j));
            if (j % 5 == 0) send_ev(NN + j, 3);
        end
        run_final(1'b0, "R7 done timing");
        check_all("R3/R4/R5/R9 sweep");

        // R11: out-of-range reads and holding of results
        for (int n = NN; n < 128; n++) begin
            rd_neuron_i = 7'(n);
            #1;
            check(rd_enable_o == 1'b0 && rd_label_o == 4'd0, "R11 range read",
                  {rd_enable_o, rd_label_o}, 0);
        end
        repeat (20) @(negedge clk);
        check_all("R11 hold");

        // R8: events and second finalise during a pass are ignored
        run_final(1'b1, "R8 pass timing");
        run_final(1'b0, "R8 repeat");
        check_all("R8 ignored");

        // R6: recent tags override older ones
        for (int k = 0; k < 10; k++) send_ev(2, 11);
        for (int k = 0; k < 10; k++) send_ev(3, (k % 5 < 3) ? 9 : 1);
        run_final(1'b0, "R6 pass");
        check_all("R6 last ten");

        // R2: count saturates instead of wrapping
        for (int k = 0; k < 300; k++) send_ev(0, 2);
        run_final(1'b0, "R2 pass");
        check_all("R2 saturate");

        // R10: clear aborts a running pass
        finalise_i = 1'b1;
        @(negedge clk);
        finalise_i = 1'b0;
        repeat (20) @(negedge clk);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        model_clear();
        begin
            int seen = 0;
            for (int k = 0; k < 150; k++) begin
                if (done_o) seen++;
                @(negedge clk);
            end
            check(seen == 0, "R10 no done", seen, 0);
        end
        check_all("R10 cleared");

        // R3/R4 boundary after clear: 9 vs 10 spikes
        for (int k = 0; k < 9; k++) send_ev(5, 7);
        for (int k = 0; k < 10; k++) send_ev(6, 15);
        run_final(1'b0, "R7 after clear");
        rd_neuron_i = 7'd5;
        #1;
        check(rd_enable_o == 1'b0, "R3 nine spikes", rd_enable_o, 0);
        rd_neuron_i = 7'd6;
        #1;
        check(rd_enable_o == 1'b1 && rd_label_o == 4'd15, "R4 ten spikes",
              {rd_enable_o, rd_label_o}, {1'b1, 4'd15});
        check_all("R3/R4 final");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule